// File: doc/BRIEF.md
# Card Data Path Progress and Timeout Tracker

This block follows one data transfer on a memory-card host controller and reports how it ends. A start pulse, taken only while idle, loads a byte count and selects a direction. A receive transfer waits for data beats until the byte count is exhausted. A transmit transfer sends its bytes, then waits for the card's acknowledge, then waits while the card signals busy. The transfer ends in one of three ways: normal completion, a data timeout, or an acknowledge timeout. Each outcome sets its own sticky flag.

Two timeout counters run on card bus clock periods, which arrive as a clock-enable input. The data timer covers the receive wait and the card-busy wait. The acknowledge timer covers only the acknowledge wait. Each timer reloads from its programmed period whenever its covered state is entered. The byte counter is visible at the ports, so software or a neighbouring block can see how far a transfer has progressed.

Top module: `data_path_tracker`

## Requirements
- R1: A start pulse in Idle with a non-zero length loads `bytes_left` with `byte_len` at that edge. The state moves to receive-wait (code 2) if `dir_rx`=1, or to send-wait (code 1) if `dir_rx`=0. The state codes are Idle=0, send-wait=1, receive-wait=2, busy=3 and acknowledge-wait=4.
- R2: Each `data_beat` cycle in send-wait or receive-wait lowers `bytes_left` by BEAT_BYTES, or by whatever remains if that is less. The count never wraps below zero.
- R3: In receive-wait, a zero byte count sends the state to Idle on the next edge and sets the data-end flag (`flags` bit 0).
- R4: In send-wait, a zero byte count moves the state to acknowledge-wait. From there, `ack_ok` moves it to busy. In busy, a low `card_busy` returns it to Idle and sets the data-end flag.
- R5: The data timer loads `data_period` on each entry into receive-wait or busy. If it is zero while in either state, the next edge goes to Idle and sets the data-timeout flag (bit 1). The data-end flag is not set for that transfer.
- R6: The acknowledge timer loads `ack_period` on entry into acknowledge-wait. If it is zero there, the next edge goes to Idle and sets the acknowledge-timeout flag (bit 2). The data-end flag is not set.
- R7: Both timers decrement only in cycles where `bus_ce` is high, so with `bus_ce` low no timeout ever occurs.
- R8: Flags stay set until the matching bit of `flag_clr` is pulsed, and each bit clears on its own. When a flag is set and cleared in the same cycle, the set wins.
- R9: A start pulse outside Idle is ignored: the state and `bytes_left` are unchanged.
- R10: A start with `byte_len`=0 keeps the state in Idle and sets the data-end flag at that edge.
- R11: After reset the state is Idle, `bytes_left` is 0 and all flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ce | input | 1 | One-cycle pulse per card bus clock period |
| start | input | 1 | Begin a transfer (honoured in Idle only) |
| dir_rx | input | 1 | 1 = receive, 0 = transmit |
| byte_len | input | LEN_W | Transfer length in bytes |
| data_period | input | TMO_W | Data timeout in bus clock periods |
| ack_period | input | TMO_W | Acknowledge timeout in bus clock periods |
| data_beat | input | 1 | One data unit of BEAT_BYTES moved this cycle |
| ack_ok | input | 1 | Card acknowledge received |
| card_busy | input | 1 | Card holds the line busy |
| flag_clr | input | 3 | Per-bit flag clear: bit 0 data-end, bit 1 data timeout, bit 2 acknowledge timeout |
| state | output | 3 | Current sequencer state code |
| bytes_left | output | LEN_W | Remaining byte count |
| flags | output | 3 | Sticky flags: bit 0 data-end, bit 1 data timeout, bit 2 acknowledge timeout |

## Verification
A timer that loads late or counts system cycles instead of bus periods moves the edge where `state` drops to Idle. That error shows up in the first timed transfer, off by at least one cycle or by the whole gap between `bus_ce` pulses. A byte counter that subtracts too much or wraps shows up on `bytes_left` at the first beat. It also makes the state leave too early, or never. A wrong priority between timeout and completion leaves data-end set next to a timeout flag, which is visible on `flags` at the edge the transfer ends.

// File: rtl/dptrk_pkg.sv
// Shared state codes and flag bit positions for the data path tracker.
package dptrk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEND = 3'd1,
        ST_RECV = 3'd2,
        ST_BUSY = 3'd3,
        ST_WACK = 3'd4
    } dp_state_t;

    localparam int FLG_DEND = 0;
    localparam int FLG_DTMO = 1;
    localparam int FLG_ATMO = 2;
    localparam int FLG_N    = 3;
endpackage

// File: rtl/dptrk_timer.sv
// Down-counting timeout timer.
// Loads the period on load. While run is high it decrements once per tick
// and stops at zero. Expired is high while running with a zero count.
// Assumes load is only raised on entry into the covered state.
module dptrk_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] period,
    input  logic         run,
    input  logic         tick,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Reload on entry, otherwise count down on bus ticks while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= period;
        else if (run && tick && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = run && (cnt_q == '0);

    AST_TMR_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q)); // R7
    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> (cnt_q <= $past(cnt_q))); // R5
endmodule

// File: rtl/dptrk_bytes.sv
// Remaining-byte counter.
// Loads the transfer length. While active, each beat subtracts BEAT_BYTES,
// or the remainder if it is smaller, so the count never wraps.
module dptrk_bytes #(
    parameter int LEN_W      = 12,
    parameter int BEAT_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             active,
    input  logic             beat,
    output logic [LEN_W-1:0] count,
    output logic             zero
);
    localparam logic [LEN_W-1:0] STEP = LEN_W'(BEAT_BYTES);

    logic [LEN_W-1:0] cnt_q;

    // Load on start, subtract a clamped step per data beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len;
        else if (active && beat)
            cnt_q <= (cnt_q > STEP) ? (cnt_q - STEP) : '0;
    end

    assign count = cnt_q;
    assign zero  = (cnt_q == '0);

    AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> (cnt_q <= $past(cnt_q))); // R2
    AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !active) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/dptrk_seq.sv
// Data path sequencer.
// Walks Idle -> send/receive wait -> (send: ack wait -> busy) -> Idle.
// Produces load/run controls for the counters and the sticky outcome flags.
// A timeout takes priority over completion in the same cycle.
module dptrk_seq
    import dptrk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_rx,
    input  logic             len_zero,
    input  logic             bytes_zero,
    input  logic             ack_ok,
    input  logic             card_busy,
    input  logic             dtmr_exp,
    input  logic             atmr_exp,
    input  logic [FLG_N-1:0] flag_clr,
    output dp_state_t        state,
    output logic [FLG_N-1:0] flags,
    output logic             byte_load,
    output logic             byte_active,
    output logic             dtmr_load,
    output logic             dtmr_run,
    output logic             atmr_load,
    output logic             atmr_run
);
    dp_state_t        st_q, nxt;
    logic [FLG_N-1:0] flg_q, flg_set;

    // Next-state and flag-set decode.
    always_comb begin
        nxt     = st_q;
        flg_set = '0;
        case (st_q)
            ST_IDLE: if (start) begin
                if (len_zero) flg_set[FLG_DEND] = 1'b1;
                else          nxt = dir_rx ? ST_RECV : ST_SEND;
            end
            ST_SEND: if (bytes_zero) nxt = ST_WACK;
            ST_RECV: begin
                if (dtmr_exp) begin
                    nxt = ST_IDLE; flg_set[FLG_DTMO] = 1'b1;
                end else if (bytes_zero) begin
                    nxt = ST_IDLE; flg_set[FLG_DEND] = 1'b1;
                end
            end
            ST_WACK: begin
                if (atmr_exp) begin
                    nxt = ST_IDLE; flg_set[FLG_ATMO] = 1'b1;
                end else if (ack_ok) begin
                    nxt = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (dtmr_exp) begin
                    nxt = ST_IDLE; flg_set[FLG_DTMO] = 1'b1;
                end else if (!card_busy) begin
                    nxt = ST_IDLE; flg_set[FLG_DEND] = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= nxt;
    end

    // Sticky flags: clear per bit, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= (flg_q & ~flag_clr) | flg_set;
    end

    assign byte_load   = (st_q == ST_IDLE) && start && !len_zero;
    assign byte_active = (st_q == ST_SEND) || (st_q == ST_RECV);
    assign dtmr_run    = (st_q == ST_RECV) || (st_q == ST_BUSY);
    assign dtmr_load   = ((nxt == ST_RECV) || (nxt == ST_BUSY)) && !dtmr_run;
    assign atmr_run    = (st_q == ST_WACK);
    assign atmr_load   = (nxt == ST_WACK) && !atmr_run;
    assign state       = st_q;
    assign flags       = flg_q;

    AST_START_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && start && !len_zero) |=> (st_q == ST_SEND || st_q == ST_RECV)); // R1
    AST_DTMO_NO_DEND: assert property (@(posedge clk) disable iff (!rst_n)
        (dtmr_exp) |=> (flg_q[FLG_DTMO] && st_q == ST_IDLE && (flg_q[FLG_DEND] <= $past(flg_q[FLG_DEND])))); // R5
    AST_ATMO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (atmr_exp) |=> (flg_q[FLG_ATMO] && st_q == ST_IDLE)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flg_q & $past(flg_q & ~flag_clr)) == $past(flg_q & ~flag_clr))); // R8
    AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && start && len_zero) |=> (st_q == ST_IDLE && flg_q[FLG_DEND])); // R10
endmodule

// File: rtl/data_path_tracker.sv
// Top: byte counter, data timer and acknowledge timer around the sequencer.
// Assumes bus_ce is a single-cycle pulse per card bus clock period.
module data_path_tracker
    import dptrk_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int TMO_W      = 8,
    parameter int BEAT_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_ce,
    input  logic             start,
    input  logic             dir_rx,
    input  logic [LEN_W-1:0] byte_len,
    input  logic [TMO_W-1:0] data_period,
    input  logic [TMO_W-1:0] ack_period,
    input  logic             data_beat,
    input  logic             ack_ok,
    input  logic             card_busy,
    input  logic [2:0]       flag_clr,
    output logic [2:0]       state,
    output logic [LEN_W-1:0] bytes_left,
    output logic [2:0]       flags
);
    dp_state_t st;
    logic byte_load, byte_active, bytes_zero;
    logic dtmr_load, dtmr_run, dtmr_exp;
    logic atmr_load, atmr_run, atmr_exp;

    dptrk_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_rx(dir_rx),
        .len_zero(byte_len == '0), .bytes_zero(bytes_zero),
        .ack_ok(ack_ok), .card_busy(card_busy),
        .dtmr_exp(dtmr_exp), .atmr_exp(atmr_exp), .flag_clr(flag_clr),
        .state(st), .flags(flags),
        .byte_load(byte_load), .byte_active(byte_active),
        .dtmr_load(dtmr_load), .dtmr_run(dtmr_run),
        .atmr_load(atmr_load), .atmr_run(atmr_run)
    );

    dptrk_bytes #(.LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_bytes (
        .clk(clk), .rst_n(rst_n), .load(byte_load), .len(byte_len),
        .active(byte_active), .beat(data_beat),
        .count(bytes_left), .zero(bytes_zero)
    );

    dptrk_timer #(.W(TMO_W)) u_dtmr (
        .clk(clk), .rst_n(rst_n), .load(dtmr_load), .period(data_period),
        .run(dtmr_run), .tick(bus_ce), .expired(dtmr_exp)
    );

    dptrk_timer #(.W(TMO_W)) u_atmr (
        .clk(clk), .rst_n(rst_n), .load(atmr_load), .period(ack_period),
        .run(atmr_run), .tick(bus_ce), .expired(atmr_exp)
    );

    assign state = st;
endmodule

// File: tb/sim_data_path_tracker.sv
// Scoreboard bench: the driver pushes expected port values, the monitor
// pops and compares them on the following falling edge.
module sim_data_path_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 12;
    localparam int TMO_W = 8;

    localparam logic [2:0] S_IDLE = 3'd0, S_SEND = 3'd1, S_RECV = 3'd2,
                           S_BUSY = 3'd3, S_WACK = 3'd4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_ce = 1'b1, start = 1'b0, dir_rx = 1'b1;
    logic [LEN_W-1:0] byte_len = '0;
    logic [TMO_W-1:0] data_period = '0, ack_period = '0;
    logic data_beat = 1'b0, ack_ok = 1'b0, card_busy = 1'b1;
    logic [2:0] flag_clr = '0;
    logic [2:0] state, flags;
    logic [LEN_W-1:0] bytes_left;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [2:0] st;
        logic [2:0] fl;
        int         cnt;   // -1: not compared
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    data_path_tracker u0 (
        .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .start(start), .dir_rx(dir_rx),
        .byte_len(byte_len), .data_period(data_period), .ack_period(ack_period),
        .data_beat(data_beat), .ack_ok(ack_ok), .card_busy(card_busy),
        .flag_clr(flag_clr), .state(state), .bytes_left(bytes_left), .flags(flags)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_now(input string tag, input logic [2:0] st,
                              input logic [2:0] fl, input int cnt);
        exp_t e;
        e.tag = tag; e.st = st; e.fl = fl; e.cnt = cnt;
        sb.push_back(e);
    endtask

    task automatic go(input logic rx, input int len);
        dir_rx = rx; byte_len = LEN_W'(len); start = 1'b1;
        step(1);
        start = 1'b0;
    endtask

    task automatic clear(input logic [2:0] m);
        flag_clr = m; step(1); flag_clr = '0;
    endtask

    // Monitor: compare queued expectations against the ports.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (state !== e.st || flags !== e.fl ||
                (e.cnt >= 0 && int'(bytes_left) != e.cnt)) begin
                fails++;
                $display("FAIL %s: state=%0d flags=%b left=%0d, expected state=%0d flags=%b left=%0d",
                         e.tag, state, flags, bytes_left, e.st, e.fl, e.cnt);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        expect_now("R11 reset", S_IDLE, 3'b000, 0);

        // Receive, 10 bytes, beats of 4 -> 6, 2, 0
        data_period = 8'd200;
        go(1'b1, 10);
        expect_now("R1 rx load", S_RECV, 3'b000, 10);
        data_beat = 1'b1; step(1);
        expect_now("R2 first beat", S_RECV, 3'b000, 6);
        step(2); data_beat = 1'b0;
        expect_now("R2 clamp to zero", S_RECV, 3'b000, 0);
        step(1);
        expect_now("R3 rx done", S_IDLE, 3'b001, 0);
        clear(3'b001);
        expect_now("R8 clear dend", S_IDLE, 3'b000, -1);

        // Zero-length transfer
        go(1'b1, 0);
        expect_now("R10 zero length", S_IDLE, 3'b001, -1);
        clear(3'b001);

        // Data timeout in receive, period 5
        data_period = 8'd5;
        go(1'b1, 8);
        step(5);
        expect_now("R5 before timeout", S_RECV, 3'b000, 8);
        step(1);
        expect_now("R5 data timeout, no dend", S_IDLE, 3'b010, -1);

        // Two flags, per-bit clear, stickiness, set beats clear
        go(1'b1, 0);
        expect_now("R8 two flags", S_IDLE, 3'b011, -1);
        clear(3'b010);
        expect_now("R8 per-bit clear", S_IDLE, 3'b001, -1);
        step(5);
        expect_now("R8 sticky", S_IDLE, 3'b001, -1);
        flag_clr = 3'b001;
        go(1'b1, 0);
        flag_clr = 3'b000;
        expect_now("R8 set wins over clear", S_IDLE, 3'b001, -1);
        clear(3'b001);

        // Bus clock gating: no countdown while bus_ce low
        data_period = 8'd3;
        bus_ce = 1'b0;
        go(1'b1, 8);
        step(40);
        expect_now("R7 no tick no timeout", S_RECV, 3'b000, 8);
        bus_ce = 1'b1;
        step(3);
        expect_now("R7 counts bus periods", S_RECV, 3'b000, 8);
        step(1);
        expect_now("R7 timeout after ticks", S_IDLE, 3'b010, -1);
        clear(3'b010);

        // Transmit full path
        data_period = 8'd100; ack_period = 8'd10; card_busy = 1'b1;
        go(1'b0, 4);
        expect_now("R1 tx load", S_SEND, 3'b000, 4);
        data_beat = 1'b1; step(1); data_beat = 1'b0;
        step(1);
        expect_now("R4 ack wait", S_WACK, 3'b000, 0);
        ack_ok = 1'b1; step(1); ack_ok = 1'b0;
        expect_now("R4 busy", S_BUSY, 3'b000, -1);
        step(2);
        expect_now("R4 busy held", S_BUSY, 3'b000, -1);
        card_busy = 1'b0; step(1); card_busy = 1'b1;
        expect_now("R4 tx done", S_IDLE, 3'b001, -1);
        clear(3'b001);

        // Acknowledge timeout, period 2
        ack_period = 8'd2;
        go(1'b0, 4);
        data_beat = 1'b1; step(1); data_beat = 1'b0;
        step(1);
        step(2);
        expect_now("R6 still waiting ack", S_WACK, 3'b000, -1);
        step(1);
        expect_now("R6 ack timeout", S_IDLE, 3'b100, -1);
        clear(3'b100);

        // Busy timeout, period 3
        data_period = 8'd3; ack_period = 8'd10;
        go(1'b0, 4);
        data_beat = 1'b1; step(1); data_beat = 1'b0;
        step(1);
        ack_ok = 1'b1; step(1); ack_ok = 1'b0;
        step(3);
        expect_now("R5 busy before timeout", S_BUSY, 3'b000, -1);
        step(1);
        expect_now("R5 busy timeout", S_IDLE, 3'b010, -1);
        clear(3'b010);

        // Start ignored while active
        data_period = 8'd6;
        go(1'b1, 20);
        go(1'b0, 4);
        expect_now("R9 start ignored", S_RECV, 3'b000, 20);
        step(10);
        expect_now("R9 original transfer times out", S_IDLE, 3'b010, 20);
        clear(3'b010);
        step(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule